// File: doc/BRIEF.md
# MDIO Management Master

This block is the management-bus master that a network controller uses to reach the registers of an external PHY. Software programs a PHY and register address, then starts either a write or a read through a small register file. The block derives the management clock from the system clock, serialises a clause-22 frame onto the data line, and releases the line when the PHY has to answer. It captures the returned 16-bit word for software to read back.

Software learns when a transfer has finished by polling the status register. The busy flag is high for the whole frame. A separate not-valid flag is set when a read is launched and clears only once the returned word has been stored. A management reset bit in the configuration register holds the clock generator and the frame engine idle. While that bit is set, the busy flag stays high.

Register offsets on the 3-bit register address: 0 configuration, 1 address, 2 command, 3 write data, 4 read data, 5 status. Every register read is combinational on the address.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, the status register reads 0. The configuration register reads 16'h0006 (reset bit 0 clear, divider select in bits 2:1 equal to 3). MDC is low and the MDIO output enable is low.
- R2: The address register keeps the register address in bits 4:0 and the PHY address in bits 12:8. All other bits read back as 0.
- R3: A register write to offset 3 while idle stores the word and starts a write frame. The frame carries, MSB first: 32 ones, 01, opcode 01, the 5-bit PHY address, the 5-bit register address, turnaround 10, and the 16 data bits. The output enable stays high for all 64 bits.
- R4: A register write to offset 2 with bit 0 set while idle starts a read frame with opcode 10. The output enable goes low from bit 46 (the first turnaround bit) to the end of the frame. MDIO is sampled on rising MDC during bits 48 to 63, and offset 4 then returns that word.
- R5: Status bit 0 (busy) is high in the first cycle after an accepted launch. It stays high for exactly 64 MDC periods, then falls.
- R6: Status bit 1 (not-valid) is high in the first cycle after a read launch. It is low once the read frame has ended and the word is readable at offset 4.
- R7: MDC idles low. MDIO and its enable change only when MDC falls, and never while MDC is high.
- R8: Divider select values 0, 1, 2 and 3 give MDC periods of 4, 8, 20 and 40 system clocks, each with a 50% duty cycle.
- R9: A write to offset 3 or offset 2 while busy is ignored. The stored word and the command bit keep their old values, and the running frame is unchanged.
- R10: While configuration bit 0 (management reset) is set, MDC and the output enable are held low, busy reads 1, not-valid reads 0, and no launch is accepted. Clearing the bit returns busy to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register offset |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for reg_addr_i |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
A wrong bit counter or shift register shows up within one frame. The captured 64-bit frame would be misordered, or the busy window would not equal 64 MDC periods. A fault in the divider or in the clock phase shows up in the count of high MDC samples and the length of the busy window. A turnaround decode error shows up as the output enable being high during sampled read bits, or as a wrong word at offset 4 once the read finishes. Faults in the busy gating and the reset hold show up in the same frame: the stored word or command bit changes, or MDC and the enable move while reset is set.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_LEN = 64;
  localparam int PRE_LEN   = 32;
  localparam int TA_POS    = 46;
  localparam int DATA_POS  = 48;
  localparam int DW        = 16;
  localparam int AW        = 5;
  localparam int IDXW      = $clog2(FRAME_LEN);
  localparam int HALFW     = 5;
  localparam int SELW      = 2;
  localparam int RAW       = 3;
  localparam int PHY_SHIFT = 8;

  typedef enum logic [RAW-1:0] {
    RA_CFG   = 3'd0,
    RA_ADDR  = 3'd1,
    RA_CMD   = 3'd2,
    RA_WDATA = 3'd3,
    RA_RDATA = 3'd4,
    RA_STAT  = 3'd5
  } reg_addr_e;

  // system clocks per MDC half period
  function automatic logic [HALFW-1:0] half_period(input logic [SELW-1:0] sel);
    case (sel)
      2'd0:    return HALFW'(2);
      2'd1:    return HALFW'(4);
      2'd2:    return HALFW'(10);
      default: return HALFW'(20);
    endcase
  endfunction
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen
  import mdio_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [HALFW-1:0] half_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [HALFW-1:0] cnt_q;
  logic             mdc_q;
  logic             wrap;

  assign wrap   = en_i && !clr_i && (cnt_q == half_i - 1'b1);
  assign rise_o = wrap && !mdc_q;
  assign fall_o = wrap && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (clr_i || !en_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r8_phase_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i) |-> (cnt_q < half_i));
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          start_i,
  input  logic          rd_i,
  input  logic [AW-1:0] phy_i,
  input  logic [AW-1:0] reg_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          mdio_i,
  output logic          busy_o,
  output logic          mdio_o,
  output logic          mdio_oe_o,
  output logic          rd_done_o,
  output logic [DW-1:0] rdata_o
);
  logic                 busy_q, rd_q;
  logic [FRAME_LEN-1:0] sh_q;
  logic [IDXW-1:0]      idx_q;
  logic [DW-1:0]        cap_q;
  logic                 last_bit;

  assign last_bit  = (idx_q == IDXW'(FRAME_LEN - 1));
  assign busy_o    = busy_q;
  assign mdio_o    = busy_q ? sh_q[FRAME_LEN-1] : 1'b1;
  assign mdio_oe_o = busy_q && !(rd_q && idx_q >= IDXW'(TA_POS));
  assign rd_done_o = busy_q && rd_q && fall_i && last_bit;
  assign rdata_o   = cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      sh_q   <= '1;
      idx_q  <= '0;
      cap_q  <= '0;
    end else if (clr_i) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      idx_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        rd_q   <= rd_i;
        idx_q  <= '0;
        sh_q   <= {{PRE_LEN{1'b1}}, 2'b01, rd_i ? 2'b10 : 2'b01, phy_i, reg_i,
                   2'b10, rd_i ? {DW{1'b0}} : wdata_i};
      end
    end else begin
      if (rise_i && rd_q && idx_q >= IDXW'(DATA_POS))
        cap_q <= {cap_q[DW-2:0], mdio_i};
      if (fall_i) begin
        if (last_bit) busy_q <= 1'b0;
        else begin
          idx_q <= idx_q + 1'b1;
          sh_q  <= {sh_q[FRAME_LEN-2:0], 1'b1};
        end
      end
    end
  end

  a_r5_no_start_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !clr_i && !(fall_i && last_bit)) |=> (busy_q && $stable(rd_q)));
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           reg_we_i,
  input  logic [RAW-1:0] reg_addr_i,
  input  logic [DW-1:0]  reg_wdata_i,
  output logic [DW-1:0]  reg_rdata_o,
  output logic           mdc_o,
  output logic           mdio_o,
  output logic           mdio_oe_o,
  input  logic           mdio_i
);
  logic            cfg_rst_q;
  logic [SELW-1:0] sel_q;
  logic [AW-1:0]   phy_q, reg_q;
  logic            cmd_rd_q, nv_q;
  logic [DW-1:0]   wd_q, rd_q;
  logic            eng_busy, eng_done, stat_busy;
  logic [DW-1:0]   eng_rdata;
  logic            rise, fall, wr_go, rd_go, start;

  assign stat_busy = eng_busy | cfg_rst_q;
  assign wr_go = reg_we_i && (reg_addr_i == RA_WDATA) && !stat_busy;
  assign rd_go = reg_we_i && (reg_addr_i == RA_CMD) && reg_wdata_i[0] && !stat_busy;
  assign start = wr_go | rd_go;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_rst_q <= 1'b0;
      sel_q     <= '1;
      phy_q     <= '0;
      reg_q     <= '0;
      cmd_rd_q  <= 1'b0;
      nv_q      <= 1'b0;
      wd_q      <= '0;
      rd_q      <= '0;
    end else begin
      if (reg_we_i) begin
        case (reg_addr_e'(reg_addr_i))
          RA_CFG:   {sel_q, cfg_rst_q} <= reg_wdata_i[SELW:0];
          RA_ADDR: begin
            reg_q <= reg_wdata_i[AW-1:0];
            phy_q <= reg_wdata_i[PHY_SHIFT +: AW];
          end
          RA_CMD:   if (!stat_busy) cmd_rd_q <= reg_wdata_i[0];
          RA_WDATA: if (!stat_busy) wd_q <= reg_wdata_i;
          default: ;
        endcase
      end
      if (cfg_rst_q)     nv_q <= 1'b0;
      else if (rd_go)    nv_q <= 1'b1;
      else if (eng_done) nv_q <= 1'b0;
      if (eng_done) rd_q <= eng_rdata;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_e'(reg_addr_i))
      RA_CFG:   reg_rdata_o[SELW:0] = {sel_q, cfg_rst_q};
      RA_ADDR: begin
        reg_rdata_o[AW-1:0]         = reg_q;
        reg_rdata_o[PHY_SHIFT +: AW] = phy_q;
      end
      RA_CMD:   reg_rdata_o[0]   = cmd_rd_q;
      RA_WDATA: reg_rdata_o      = wd_q;
      RA_RDATA: reg_rdata_o      = rd_q;
      RA_STAT:  reg_rdata_o[1:0] = {nv_q, stat_busy};
      default: ;
    endcase
  end

  mdio_clk_gen i_clk_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cfg_rst_q),
    .en_i   (eng_busy),
    .half_i (half_period(sel_q)),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_frame_eng i_frame_eng (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (cfg_rst_q),
    .start_i   (start),
    .rd_i      (rd_go),
    .phy_i     (phy_q),
    .reg_i     (reg_q),
    .wdata_i   (reg_wdata_i),
    .rise_i    (rise),
    .fall_i    (fall),
    .mdio_i    (mdio_i),
    .busy_o    (eng_busy),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .rd_done_o (eng_done),
    .rdata_o   (eng_rdata)
  );

  a_r5_busy_on_launch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> stat_busy);
  a_r6_nv_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_go |=> nv_q);
  a_r6_nv_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_done |=> !nv_q);
  a_r7_mdio_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdc_o && $past(mdc_o)) |-> ($stable(mdio_o) && $stable(mdio_oe_o)));
  a_r9_wd_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == RA_WDATA && stat_busy) |=> $stable(wd_q));
  a_r10_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rst_q && $past(cfg_rst_q)) |-> (!mdc_o && !mdio_oe_o));
endmodule

// File: tb/test_mdio_mgmt_master.sv
`timescale 1ns/1ps
module test_mdio_mgmt_master;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd5;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mdio_mgmt_master i_mdio_mgmt_master (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .mdc_o(mdc),
    .mdio_o(mdio_o), .mdio_oe_o(mdio_oe), .mdio_i(mdio_i)
  );

  // PHY model
  int          phy_cnt = 0;
  int          base = 0;
  logic [63:0] cap = '0;
  logic [15:0] resp = '0;
  bit          exp_rd = 1'b0;
  int          oe_err = 0;

  always @(posedge mdc) begin
    if (exp_rd && (phy_cnt - base) >= 46 && mdio_oe) oe_err++;
    if (!exp_rd && !mdio_oe) oe_err++;
    cap <= {cap[62:0], mdio_oe ? mdio_o : mdio_i};
    phy_cnt++;
  end

  always @(negedge mdc) begin
    int idx;
    idx = phy_cnt - base;
    if (idx == 47) mdio_i <= 1'b0;
    else if (idx >= 48 && idx <= 63) mdio_i <= resp[63-idx];
    else mdio_i <= 1'b1;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 3'd5;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    reg_addr = a;
    #0.1;
    d = reg_rdata;
    reg_addr = 3'd5;
    #0.1;
  endtask

  typedef struct packed {
    logic       is_rd;
    logic [1:0] sel;
    logic [4:0] phy;
    logic [4:0] rg;
    logic [15:0] data;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 5'h01, 5'h00, 16'hA5C3},
    '{1'b1, 2'd0, 5'h1F, 5'h1F, 16'h8001},
    '{1'b0, 2'd1, 5'h10, 5'h0A, 16'hFFFF},
    '{1'b1, 2'd2, 5'h05, 5'h11, 16'h1234},
    '{1'b0, 2'd0, 5'h00, 5'h1E, 16'h0000},
    '{1'b1, 2'd3, 5'h0C, 5'h02, 16'hBEEF},
    '{1'b1, 2'd0, 5'h15, 5'h0B, 16'h0F0F}
  };

  function automatic logic [63:0] frame_of(vec_t v);
    return {32'hFFFF_FFFF, 2'b01, v.is_rd ? 2'b10 : 2'b01, v.phy, v.rg, 2'b10, v.data};
  endfunction

  function automatic int div_of(logic [1:0] s);
    case (s) 2'd0: return 4; 2'd1: return 8; 2'd2: return 20; default: return 40; endcase
  endfunction

  // wait for busy low; returns busy and mdc-high sample counts, mdio-change-while-high count
  task automatic wait_idle(output int nbusy, output int nhi, output int nchg);
    logic [15:0] s;
    logic pm, pd, pe;
    nbusy = 0; nhi = 0; nchg = 0;
    pm = mdc; pd = mdio_o; pe = mdio_oe;
    rd(3'd5, s);
    while (s[0] && nbusy < 5000) begin
      nbusy++;
      if (mdc) nhi++;
      if (mdc && pm && (mdio_o !== pd || mdio_oe !== pe)) nchg++;
      pm = mdc; pd = mdio_o; pe = mdio_oe;
      @(negedge clk);
      rd(3'd5, s);
    end
  endtask

  task automatic run_vec(input vec_t v);
    logic [15:0] s;
    int nb, nh, nc, oe0, dv;
    dv = div_of(v.sel);
    wr(3'd0, {13'b0, v.sel, 1'b0});
    wr(3'd1, {3'b0, v.phy, 3'b0, v.rg});
    rd(3'd1, s);
    chk("R2 addr readback", s, {3'b0, v.phy, 3'b0, v.rg});
    base = phy_cnt; exp_rd = v.is_rd; resp = v.data; oe0 = oe_err;
    if (v.is_rd) wr(3'd2, 16'h0001); else wr(3'd3, v.data);
    rd(3'd5, s);
    chk("R5 busy after launch", s[0], 1'b1);
    chk("R6 not-valid after launch", s[1], v.is_rd);
    wait_idle(nb, nh, nc);
    chk("R5 busy window", nb, 64 * dv);
    chk("R8 mdc high time", nh, 32 * dv);
    chk("R7 mdio moved while mdc high", nc, 0);
    chk("R7 mdc idle low", mdc, 1'b0);
    chk(v.is_rd ? "R4 read frame" : "R3 write frame", cap, frame_of(v));
    chk(v.is_rd ? "R4 oe released" : "R3 oe held", oe_err - oe0, 0);
    if (v.is_rd) begin
      rd(3'd4, s);
      chk("R4 read data", s, v.data);
      rd(3'd5, s);
      chk("R6 not-valid cleared", s[1], 1'b0);
      wr(3'd2, 16'h0000);
      rd(3'd2, s);
      chk("R4 cmd cleared", s, 16'h0);
    end
  endtask

  initial begin
    logic [15:0] s;
    int nb, nh, nc;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(3'd5, s); chk("R1 status", s, 16'h0);
    rd(3'd0, s); chk("R1 cfg", s, 16'h0006);
    chk("R1 mdc", mdc, 1'b0);
    chk("R1 oe", mdio_oe, 1'b0);

    // R2 masking
    wr(3'd1, 16'hFFFF);
    rd(3'd1, s); chk("R2 field mask", s, 16'h1F1F);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R9 ignored writes while busy
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'h0304);
    base = phy_cnt; exp_rd = 1'b0;
    wr(3'd3, 16'h5A5A);
    repeat (10) @(negedge clk);
    wr(3'd3, 16'hC0DE);
    wr(3'd2, 16'h0001);
    rd(3'd3, s); chk("R9 wdata kept", s, 16'h5A5A);
    rd(3'd2, s); chk("R9 cmd kept", s, 16'h0);
    rd(3'd5, s); chk("R9 no read started", s[1], 1'b0);
    wait_idle(nb, nh, nc);
    chk("R9 frame unchanged", cap, {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h03, 5'h04, 2'b10, 16'h5A5A});

    // R10 management reset mid-frame
    base = phy_cnt;
    wr(3'd3, 16'h1111);
    repeat (37) @(negedge clk);
    wr(3'd0, 16'h0001);
    @(negedge clk);
    rd(3'd5, s); chk("R10 busy in reset", s, 16'h0001);
    chk("R10 mdc held", mdc, 1'b0);
    chk("R10 oe held", mdio_oe, 1'b0);
    wr(3'd2, 16'h0001);
    rd(3'd5, s); chk("R10 read launch ignored", s[1], 1'b0);
    repeat (20) @(negedge clk);
    chk("R10 mdc still low", mdc, 1'b0);
    wr(3'd0, 16'h0000);
    rd(3'd5, s); chk("R10 busy released", s, 16'h0);
    repeat (20) @(negedge clk);
    chk("R10 no frame after release", mdc, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
      $finish;
    end
  end
endmodule